// File: doc/BRIEF.md
# Sub-Lane Register File with Partial-Width Write Merge

This block holds a bank of 64-bit general registers that can be written and read through narrower lanes: the low byte, the second byte (bits 15:8), the low half-word, the low 32-bit word, or the whole 64 bits. On a write, the incoming value is merged into the stored register by a per-lane rule. Byte and half-word writes keep every bit they do not cover. A word write stores its 32 bits and clears the upper 32. A full write replaces everything.

The write value comes either from a 64-bit result bus or from an immediate operand. A short signed literal is sign-extended before the merge. Half-word and word literals are accepted at their full width and are sign-extended to 64 bits, so a word literal used with a 64-bit write fills the upper half with its sign. Illegal requests are flagged on `wr_err` in the same cycle and leave the bank untouched. These are an unknown lane code, the second-byte lane on a register that lacks it, and a reserved immediate format.

Two combinational read ports return the selected lane zero-extended to 64 bits. The block has no sequencing of its own: a single storage process updates the bank at each rising edge, and the merge, widening and extraction paths are pure combinational logic.

Top module: `subreg_file`

## Requirements
- R1: Lane code 3'b000 (low byte) on an accepted write changes bits 7:0 to the source's bits 7:0 and keeps bits 63:8.
- R2: Lane code 3'b001 (second byte) on an accepted write to registers 0 to 3 changes bits 15:8 to the source's bits 7:0 and keeps all other bits.
- R3: Lane code 3'b010 (half-word) changes bits 15:0 to the source's bits 15:0 and keeps bits 63:16.
- R4: Lane code 3'b011 (word) stores the source's bits 31:0 in bits 31:0 and forces bits 63:32 to zero.
- R5: Lane code 3'b100 (double) replaces all 64 bits with the source.
- R6: With `wr_en` high, `wr_err` goes high in the same cycle and no register changes if any of these holds: the lane code is 3'b101 to 3'b111; the lane is 3'b001 with an index of 4 or more; or `wr_use_imm` is high with `imm_fmt` 2'b11. Otherwise `wr_err` is low.
- R7: With `wr_use_imm` high, the source is built as follows: `imm_fmt` 2'b00 sign-extends `imm_val[7:0]`, 2'b01 sign-extends `imm_val[15:0]`, and 2'b10 sign-extends `imm_val[31:0]`, each to 64 bits. The result is then merged by the lane rules.
- R8: Each read port returns its lane zero-extended: low byte, second byte, half-word, word or double. It returns zero for lane codes 3'b101 to 3'b111 and for lane 3'b001 on index 4 or above.
- R9: Reads are combinational, and a read of a register being written in the same cycle returns the value held before the edge.
- R10: Synchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register written |
| wr_lane | input | 3 | Lane code of the write |
| wr_data | input | 64 | Result-bus source |
| wr_use_imm | input | 1 | Take the source from the immediate path |
| imm_val | input | 32 | Immediate literal |
| imm_fmt | input | 2 | Immediate format (8, 16, 32 bit, reserved) |
| wr_err | output | 1 | Write request rejected |
| rda_idx | input | 4 | Read port A register |
| rda_lane | input | 3 | Read port A lane code |
| rda_data | output | 64 | Read port A zero-extended lane |
| rdb_idx | input | 4 | Read port B register |
| rdb_lane | input | 3 | Read port B lane code |
| rdb_data | output | 64 | Read port B zero-extended lane |

## Verification
The bench uses the default parameters: sixteen registers, with the second-byte lane on the first four. Both boundaries are therefore exercised. Index 3 is the last register that accepts the second-byte lane, and index 4 is the first that rejects it. The four-bit index covers the whole bank with no holes. Random write sequences mix every lane, source and immediate format over all sixteen registers, so the upper bits kept by byte and half-word writes, and cleared by word writes, are compared against a behavioural model every clock.

// File: rtl/subreg_pkg.sv
package subreg_pkg;
    localparam int XLEN = 64;
    localparam int IMMW = 32;

    typedef enum logic [2:0] {
        LANE_B0 = 3'b000,
        LANE_B1 = 3'b001,
        LANE_HW = 3'b010,
        LANE_WD = 3'b011,
        LANE_DW = 3'b100
    } lane_e;

    typedef enum logic [1:0] {
        IMM_S8  = 2'b00,
        IMM_S16 = 2'b01,
        IMM_S32 = 2'b10,
        IMM_RSV = 2'b11
    } immfmt_e;
endpackage

// File: rtl/imm_widen.sv
module imm_widen
    import subreg_pkg::*;
(
    input  logic [IMMW-1:0] imm_val,
    input  logic [1:0]      imm_fmt,
    output logic [XLEN-1:0] imm_ext,
    output logic            imm_bad
);
    always_comb begin
        imm_ext = '0;
        imm_bad = 1'b0;
        unique case (immfmt_e'(imm_fmt))
            IMM_S8:  imm_ext = {{(XLEN-8){imm_val[7]}}, imm_val[7:0]};
            IMM_S16: imm_ext = {{(XLEN-16){imm_val[15]}}, imm_val[15:0]};
            IMM_S32: imm_ext = {{(XLEN-32){imm_val[31]}}, imm_val[31:0]};
            IMM_RSV: imm_bad = 1'b1;
            default: imm_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import subreg_pkg::*;
(
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [2:0]      lane,
    output logic [XLEN-1:0] merged,
    output logic            lane_ok
);
    always_comb begin
        merged  = old_val;
        lane_ok = 1'b1;
        unique case (lane_e'(lane))
            LANE_B0: merged[7:0]  = src_val[7:0];
            LANE_B1: merged[15:8] = src_val[7:0];
            LANE_HW: merged[15:0] = src_val[15:0];
            LANE_WD: merged       = {{(XLEN-32){1'b0}}, src_val[31:0]};
            LANE_DW: merged       = src_val;
            default: lane_ok      = 1'b0;
        endcase
    end
endmodule

// File: rtl/lane_extract.sv
module lane_extract
    import subreg_pkg::*;
(
    input  logic [XLEN-1:0] word,
    input  logic [2:0]      lane,
    output logic [XLEN-1:0] lane_data,
    output logic            lane_ok
);
    always_comb begin
        lane_data = '0;
        lane_ok   = 1'b1;
        unique case (lane_e'(lane))
            LANE_B0: lane_data[7:0]  = word[7:0];
            LANE_B1: lane_data[7:0]  = word[15:8];
            LANE_HW: lane_data[15:0] = word[15:0];
            LANE_WD: lane_data[31:0] = word[31:0];
            LANE_DW: lane_data       = word;
            default: lane_ok         = 1'b0;
        endcase
    end
endmodule

// File: rtl/subreg_file.sv
module subreg_file
    import subreg_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int HI_REGS = 4,
    parameter int IDXW    = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [2:0]      wr_lane,
    input  logic [XLEN-1:0] wr_data,
    input  logic            wr_use_imm,
    input  logic [IMMW-1:0] imm_val,
    input  logic [1:0]      imm_fmt,
    output logic            wr_err,
    input  logic [IDXW-1:0] rda_idx,
    input  logic [2:0]      rda_lane,
    output logic [XLEN-1:0] rda_data,
    input  logic [IDXW-1:0] rdb_idx,
    input  logic [2:0]      rdb_lane,
    output logic [XLEN-1:0] rdb_data
);
    localparam int NRD = 2;

    logic [XLEN-1:0] regs [NREG];

    // write path
    logic [XLEN-1:0] imm_ext, src_val, merged;
    logic            imm_bad, lane_ok, hi_ok, imm_ok, accept;

    imm_widen u_widen (
        .imm_val (imm_val),
        .imm_fmt (imm_fmt),
        .imm_ext (imm_ext),
        .imm_bad (imm_bad)
    );

    assign src_val = wr_use_imm ? imm_ext : wr_data;

    lane_merge u_merge (
        .old_val (regs[wr_idx]),
        .src_val (src_val),
        .lane    (wr_lane),
        .merged  (merged),
        .lane_ok (lane_ok)
    );

    assign hi_ok  = (wr_lane != LANE_B1) || (int'(wr_idx) < HI_REGS);
    assign imm_ok = !wr_use_imm || !imm_bad;
    assign accept = wr_en && lane_ok && hi_ok && imm_ok;
    assign wr_err = wr_en && !(lane_ok && hi_ok && imm_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (accept) begin
            regs[wr_idx] <= merged;
        end
    end

    // read ports
    logic [IDXW-1:0] rd_idx  [NRD];
    logic [2:0]      rd_lane [NRD];
    logic [XLEN-1:0] rd_out  [NRD];

    assign rd_idx[0]  = rda_idx;
    assign rd_idx[1]  = rdb_idx;
    assign rd_lane[0] = rda_lane;
    assign rd_lane[1] = rdb_lane;
    assign rda_data   = rd_out[0];
    assign rdb_data   = rd_out[1];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [XLEN-1:0] lane_data;
        logic            ext_ok, port_hi_ok;

        lane_extract u_ext (
            .word      (regs[rd_idx[p]]),
            .lane      (rd_lane[p]),
            .lane_data (lane_data),
            .lane_ok   (ext_ok)
        );

        assign port_hi_ok = (rd_lane[p] != LANE_B1) || (int'(rd_idx[p]) < HI_REGS);
        assign rd_out[p]  = (ext_ok && port_hi_ok) ? lane_data : '0;
    end

    // checks: snapshot of the register before each write, compared one edge later
    logic            chk_v, chk_rej;
    logic [IDXW-1:0] chk_idx;
    logic [2:0]      chk_lane;
    logic [XLEN-1:0] chk_old, chk_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_v    <= 1'b0;
            chk_rej  <= 1'b0;
            chk_idx  <= '0;
            chk_lane <= '0;
            chk_old  <= '0;
            chk_src  <= '0;
        end else begin
            chk_v    <= accept;
            chk_rej  <= wr_en && !accept;
            chk_idx  <= wr_idx;
            chk_lane <= wr_lane;
            chk_old  <= regs[wr_idx];
            chk_src  <= src_val;
        end
    end

    assert_lowbyte_keep_R1: assert property (@(posedge clk) disable iff (rst)
        (chk_v && chk_lane == LANE_B0) |->
        (regs[chk_idx][XLEN-1:8] == chk_old[XLEN-1:8] && regs[chk_idx][7:0] == chk_src[7:0]));

    assert_hibyte_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (chk_v && chk_lane == LANE_B1) |->
        (regs[chk_idx][XLEN-1:16] == chk_old[XLEN-1:16] && regs[chk_idx][7:0] == chk_old[7:0]
         && regs[chk_idx][15:8] == chk_src[7:0]));

    assert_half_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (chk_v && chk_lane == LANE_HW) |-> regs[chk_idx][XLEN-1:16] == chk_old[XLEN-1:16]);

    assert_word_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (chk_v && chk_lane == LANE_WD) |-> regs[chk_idx][XLEN-1:32] == '0);

    assert_reject_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
        chk_rej |-> regs[chk_idx] == chk_old);

    assert_badlane_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rda_lane > 3'b100) |-> rda_data == '0);
endmodule

// File: tb/subreg_file_tb.sv
module subreg_file_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_use_imm;
    logic [3:0]  wr_idx, rda_idx, rdb_idx;
    logic [2:0]  wr_lane, rda_lane, rdb_lane;
    logic [63:0] wr_data;
    logic [31:0] imm_val;
    logic [1:0]  imm_fmt;
    logic        wr_err;
    logic [63:0] rda_data, rdb_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] model [16];

    always #4 clk = ~clk;

    subreg_file dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_lane(wr_lane),
        .wr_data(wr_data), .wr_use_imm(wr_use_imm), .imm_val(imm_val), .imm_fmt(imm_fmt),
        .wr_err(wr_err), .rda_idx(rda_idx), .rda_lane(rda_lane), .rda_data(rda_data),
        .rdb_idx(rdb_idx), .rdb_lane(rdb_lane), .rdb_data(rdb_data)
    );

    function automatic logic [63:0] m_read(int idx, int lane);
        logic [63:0] v = model[idx];
        case (lane)
            0: return 64'(v[7:0]);
            1: return (idx < 4) ? 64'(v[15:8]) : 64'd0;
            2: return 64'(v[15:0]);
            3: return 64'(v[31:0]);
            4: return v;
            default: return 64'd0;
        endcase
    endfunction

    function automatic logic [63:0] m_source(bit use_imm, logic [63:0] d, logic [31:0] iv, int fmt);
        if (!use_imm) return d;
        case (fmt)
            0: return 64'($signed(iv[7:0]));
            1: return 64'($signed(iv[15:0]));
            default: return 64'($signed(iv));
        endcase
    endfunction

    function automatic bit m_reject(int idx, int lane, bit use_imm, int fmt);
        return (lane > 4) || (lane == 1 && idx >= 4) || (use_imm && fmt == 3);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit en, int idx, int lane, logic [63:0] d, bit use_imm,
                        logic [31:0] iv, int fmt, int ra, int la, int rb, int lb, string tag);
        logic [63:0] s, v;
        @(negedge clk);
        wr_en = en; wr_idx = 4'(idx); wr_lane = 3'(lane); wr_data = d;
        wr_use_imm = use_imm; imm_val = iv; imm_fmt = 2'(fmt);
        rda_idx = 4'(ra); rda_lane = 3'(la); rdb_idx = 4'(rb); rdb_lane = 3'(lb);
        #1;
        check({tag, " wr_err R6"}, 64'(wr_err), 64'(en && m_reject(idx, lane, use_imm, fmt)));
        check({tag, " portA R8/R9"}, rda_data, m_read(ra, la));
        check({tag, " portB R8/R9"}, rdb_data, m_read(rb, lb));
        @(posedge clk);
        if (en && !m_reject(idx, lane, use_imm, fmt)) begin
            s = m_source(use_imm, d, iv, fmt);
            v = model[idx];
            case (lane)
                0: v[7:0] = s[7:0];
                1: v[15:8] = s[7:0];
                2: v[15:0] = s[15:0];
                3: v = 64'(s[31:0]);
                default: v = s;
            endcase
            model[idx] = v;
        end
    endtask

    task automatic wr(int idx, int lane, logic [63:0] d, string tag);
        step(1, idx, lane, d, 0, 0, 0, idx, 4, idx, lane, tag);
    endtask

    task automatic wimm(int idx, int lane, logic [31:0] iv, int fmt, string tag);
        step(1, idx, lane, 0, 1, iv, fmt, idx, 4, idx, lane, tag);
    endtask

    task automatic peek(int idx, logic [63:0] exp, string tag);
        step(0, 0, 0, 0, 0, 0, 0, idx, 4, idx, 4, tag);
        check({tag, " full"}, rda_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 64'd0;
        rst = 1; wr_en = 0; wr_idx = 0; wr_lane = 0; wr_data = 0; wr_use_imm = 0;
        imm_val = 0; imm_fmt = 0; rda_idx = 0; rda_lane = 0; rdb_idx = 0; rdb_lane = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R10: reset state
        for (int i = 0; i < 16; i++) peek(i, 64'd0, "R10 reset");

        wr(5, 4, 64'h1122334455667788, "R5 double");
        peek(5, 64'h1122334455667788, "R5");
        wr(5, 0, 64'hFFFF_FFFF_FFFF_FFAA, "R1 lowbyte");
        peek(5, 64'h11223344556677AA, "R1");
        wr(5, 2, 64'h0000_0000_0000_BEEF, "R3 half");
        peek(5, 64'h112233445566BEEF, "R3");
        wr(5, 3, 64'hFFFF_FFFF_DEAD_BEEF, "R4 word");
        peek(5, 64'h00000000DEADBEEF, "R4");
        wr(2, 4, 64'hA5A5A5A5A5A5A5A5, "R5 r2");
        wr(2, 1, 64'h0000_0000_0000_003C, "R2 hibyte");
        peek(2, 64'hA5A5A5A5A5A53CA5, "R2");
        wr(3, 1, 64'h7E, "R2 r3");
        peek(3, 64'h0000000000007E00, "R2 r3");
        wr(4, 4, 64'h0123456789ABCDEF, "R5 r4");
        wr(4, 1, 64'h00, "R6 hibyte r4");
        peek(4, 64'h0123456789ABCDEF, "R6 unchanged r4");
        wr(4, 5, 64'h0, "R6 lane5");
        wr(4, 7, 64'h0, "R6 lane7");
        peek(4, 64'h0123456789ABCDEF, "R6 unchanged lane");
        wimm(9, 4, 32'h0000_0080, 0, "R7 s8 double");
        peek(9, 64'hFFFFFFFFFFFFFF80, "R7 s8");
        wimm(9, 3, 32'h0000_0081, 0, "R7 s8 word");
        peek(9, 64'h00000000FFFFFF81, "R7 s8 word");
        wimm(9, 2, 32'h0000_8001, 1, "R7 s16 half");
        peek(9, 64'h00000000FFFF8001, "R7 s16");
        wimm(9, 4, 32'h8000_0000, 2, "R7 s32 double");
        peek(9, 64'hFFFFFFFF80000000, "R7 s32");
        wimm(9, 4, 32'h1, 3, "R6 imm reserved");
        peek(9, 64'hFFFFFFFF80000000, "R6 imm unchanged");
        // R9: same-cycle read of the written register sees the old value
        step(1, 9, 4, 64'h5, 0, 0, 0, 9, 4, 9, 0, "R9 same-cycle");
        peek(9, 64'h5, "R9 after");
        // R8 bad-lane reads
        step(0, 0, 0, 0, 0, 0, 0, 4, 1, 2, 6, "R8 bad reads");

        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 9) != 0, $urandom_range(0, 15), $urandom_range(0, 7),
                 {$urandom, $urandom}, $urandom_range(0, 2) == 0, $urandom,
                 $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 7),
                 $urandom_range(0, 15), $urandom_range(0, 7), "random R1-mix");
        end

        for (int i = 0; i < 16; i++)
            for (int l = 0; l < 8; l++)
                step(0, 0, 0, 0, 0, 0, 0, i, l, i, 4, "R8 scan");

        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int i = 0; i < 16; i++) model[i] = 64'd0;
        for (int i = 0; i < 16; i++) peek(i, 64'd0, "R10 second reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule